// File: doc/BRIEF.md
# Oversampled Asynchronous Receiver with Break Measurement

This block receives asynchronous serial characters from a single line, timed by a clock enable that pulses sixteen times per bit. A falling edge opens a character only when the line is still low at the middle of the start bit. Eight data bits follow, least significant first, then an optional parity bit and one stop bit. Each finished character leaves as a one-cycle strobe carrying the byte and three status flags. A buffer manager downstream uses these flags to decide whether to close its current buffer.

A character that is all zeros and whose stop bit samples low is a break. On a break the block raises a break status on that character and, if enabled, a break interrupt pulse. It also increments a saturating event counter and times how long the line stays low. The duration is counted in character times and placed in a length register when the line goes high again. While the line rests high after a character, the block counts idle character times. When a programmable number of them has passed, it raises an idle-close pulse. The line input must already be synchronous to `clk`.

Top module: `uart_brk_rx`

## Requirements
- R1: A low level seen on a tick while idle opens a character only if the line is still low on the 8th following tick. Otherwise the receiver goes back to idle and delivers nothing.
- R2: Data bits are sampled every 16 ticks after the mid-start sample, least significant bit first. `char_valid` pulses for one cycle, with the byte on `char_data`, in the cycle after the tick that samples the stop bit.
- R3: A stop bit that samples low sets `frame_err`, and the byte is still delivered. In that case `par_err` stays 0.
- R4: With `par_en`=1, one parity bit follows the data. Parity is even when `par_odd`=0 and odd when `par_odd`=1. A mismatch on a character whose stop bit samples high sets `par_err`.
- R5: A character with data 0x00 and a low stop bit is delivered with `char_brk`=1. `brk_pulse` rises with it only if `brk_irq_en`=1.
- R6: `brk_count` increments once per break and holds at all ones. `brk_cnt_clr` clears it on the next edge and takes priority over an increment.
- R7: The break length is 1 plus the number of whole character times (16 ticks per bit × (10 + `par_en`) bits) of low line counted after the break's stop sample. It saturates at all ones and is written to `brk_len` on the first tick with the line high.
- R8: After each delivered character, every whole character time of high line counts as one idle character. When the count reaches `idle_thresh`, `idle_close` pulses once. A low line resets the count. `idle_thresh`=0 disables the pulse.
- R9: During reset, all output pulses, flags, data, counter and length read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, already synchronous |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| brk_irq_en | input | 1 | Enables the break pulse |
| brk_cnt_clr | input | 1 | Synchronous clear of the break counter |
| idle_thresh | input | THR_W | Idle characters before idle-close, 0 disables |
| char_valid | output | 1 | One-cycle character strobe |
| char_data | output | 8 | Received byte |
| frame_err | output | 1 | Stop bit sampled low |
| par_err | output | 1 | Parity mismatch |
| char_brk | output | 1 | Character is a break |
| brk_pulse | output | 1 | Break interrupt pulse |
| idle_close | output | 1 | Idle threshold reached |
| brk_count | output | CNT_W | Saturating break event count |
| brk_len | output | LEN_W | Length of the last break in character times |

## Verification
The hardest states to reach from the ports are the saturation limits of the break counter and of the break length. At full width they would take tens of thousands of breaks, or a break of tens of thousands of character times. The bench therefore builds the block with narrow counter and length widths. It then sends enough back-to-back short breaks, and one low period longer than seven character times, to pin both at all ones. A clear is then issued and checked. A behavioural model counts ticks from each falling edge and compares every output on every clock. It also checks the rejected start glitch, and a framing error combined with bad parity.

// File: rtl/uart_brk_rx.sv
module uart_brk_rx #(
  parameter int OVS   = 16,
  parameter int CNT_W = 16,
  parameter int LEN_W = 16,
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             brk_irq_en,
  input  logic             brk_cnt_clr,
  input  logic [THR_W-1:0] idle_thresh,
  output logic             char_valid,
  output logic [7:0]       char_data,
  output logic             frame_err,
  output logic             par_err,
  output logic             char_brk,
  output logic             brk_pulse,
  output logic             idle_close,
  output logic [CNT_W-1:0] brk_count,
  output logic [LEN_W-1:0] brk_len
);
  localparam int BW = $clog2(OVS);
  localparam int TW = $clog2(OVS*11 + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  st_t              st;
  logic [BW-1:0]    bt;
  logic [2:0]       bn;
  logic [7:0]       sh;
  logic             pb;
  logic [TW-1:0]    sub, isub;
  logic [LEN_W-1:0] len;
  logic [THR_W-1:0] icnt;
  logic             armed;

  wire [TW-1:0] ct_m1   = par_en ? TW'(OVS*11 - 1) : TW'(OVS*10 - 1);
  wire          bit_end = (bt == BW'(OVS - 1));
  wire          mid     = (bt == BW'(OVS/2 - 1));
  wire          frm     = !rxd;
  wire          brk_hit = frm && (sh == 8'h00);
  wire          bad_par = ((^sh) ^ pb) != par_odd;
  wire [THR_W-1:0] icnt_n = icnt + THR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; bt <= '0; bn <= '0; sh <= '0; pb <= 1'b0;
      sub <= '0; isub <= '0; len <= '0; icnt <= '0; armed <= 1'b0;
      char_valid <= 1'b0; char_data <= '0; frame_err <= 1'b0; par_err <= 1'b0;
      char_brk <= 1'b0; brk_pulse <= 1'b0; idle_close <= 1'b0;
      brk_count <= '0; brk_len <= '0;
    end else begin
      char_valid <= 1'b0;
      brk_pulse  <= 1'b0;
      idle_close <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE:
            if (!rxd) begin
              st <= S_START; bt <= '0; isub <= '0; icnt <= '0;
            end else if (isub == ct_m1) begin
              isub <= '0;
              if (armed && idle_thresh != '0) begin
                icnt <= icnt_n;
                if (icnt_n == idle_thresh) begin
                  idle_close <= 1'b1;
                  armed      <= 1'b0;
                end
              end
            end else begin
              isub <= isub + TW'(1);
            end
          S_START:
            if (mid) begin
              st <= rxd ? S_IDLE : S_DATA;
              bt <= '0;
              bn <= '0;
            end else begin
              bt <= bt + BW'(1);
            end
          S_DATA:
            if (bit_end) begin
              sh <= {rxd, sh[7:1]};
              bt <= '0;
              bn <= bn + 3'd1;
              if (bn == 3'd7) st <= par_en ? S_PAR : S_STOP;
            end else begin
              bt <= bt + BW'(1);
            end
          S_PAR:
            if (bit_end) begin
              pb <= rxd; bt <= '0; st <= S_STOP;
            end else begin
              bt <= bt + BW'(1);
            end
          S_STOP:
            if (bit_end) begin
              char_valid <= 1'b1;
              char_data  <= sh;
              frame_err  <= frm;
              par_err    <= par_en && !frm && bad_par;
              char_brk   <= brk_hit;
              armed      <= 1'b1;
              isub       <= '0;
              icnt       <= '0;
              bt         <= '0;
              if (brk_hit) begin
                st        <= S_BRK;
                sub       <= '0;
                len       <= LEN_W'(1);
                brk_pulse <= brk_irq_en;
                if (brk_count != '1) brk_count <= brk_count + CNT_W'(1);
              end else begin
                st <= S_IDLE;
              end
            end else begin
              bt <= bt + BW'(1);
            end
          S_BRK:
            if (rxd) begin
              brk_len <= len;
              st      <= S_IDLE;
            end else if (sub == ct_m1) begin
              sub <= '0;
              if (len != '1) len <= len + LEN_W'(1);
            end else begin
              sub <= sub + TW'(1);
            end
          default: st <= S_IDLE;
        endcase
      end
      if (brk_cnt_clr) brk_count <= '0;
    end
  end

  p_glitch_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick && mid && rxd) |=> (st == S_IDLE));

  p_frame_masks_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && frame_err) |-> !par_err);

  p_brk_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_brk) |-> (frame_err && char_data == 8'h00));

  p_brk_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> (char_valid && char_brk && brk_irq_en));

  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_cnt_clr |=> (brk_count == '0));

  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_count == '1 && !brk_cnt_clr) |=> (brk_count == '1));

  p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_BRK) |=> $stable(brk_len));

  p_idle_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_close |-> !char_valid);
endmodule

// File: tb/test_uart_brk_rx.sv
module test_uart_brk_rx;
  localparam int CW = 3, LW = 3, TH = 16;
  localparam int CMAX = (1 << CW) - 1, LMAX = (1 << LW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, brk_irq_en = 1'b1, brk_cnt_clr = 1'b0;
  logic [TH-1:0] idle_thresh = '0;
  logic char_valid, frame_err, par_err, char_brk, brk_pulse, idle_close;
  logic [7:0] char_data;
  logic [CW-1:0] brk_count;
  logic [LW-1:0] brk_len;

  uart_brk_rx #(.OVS(16), .CNT_W(CW), .LEN_W(LW), .THR_W(TH)) i_uart_brk_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_en(par_en),
    .par_odd(par_odd), .brk_irq_en(brk_irq_en), .brk_cnt_clr(brk_cnt_clr),
    .idle_thresh(idle_thresh), .char_valid(char_valid), .char_data(char_data),
    .frame_err(frame_err), .par_err(par_err), .char_brk(char_brk),
    .brk_pulse(brk_pulse), .idle_close(idle_close), .brk_count(brk_count),
    .brk_len(brk_len));

  always #4 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  int n_run = 0, n_fail = 0, n_valid = 0, n_close = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: tick positions measured from each falling edge
  int m_mode = 0, m_t = 0, m_hi = 0, m_low = 0, m_acc = 0, m_pb = 0;
  bit m_armed = 0;
  int e_valid = 0, e_data = 0, e_fr = 0, e_pe = 0, e_brk = 0, e_bp = 0,
      e_close = 0, e_cnt = 0, e_len = 0;

  always @(posedge clk) begin
    int ct, stop_at, k;
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_hi = 0; m_armed = 0; m_acc = 0;
      e_valid = 0; e_data = 0; e_fr = 0; e_pe = 0; e_brk = 0; e_bp = 0;
      e_close = 0; e_cnt = 0; e_len = 0;
    end else begin
      e_valid = 0; e_bp = 0; e_close = 0;
      ct = 16 * (10 + (par_en ? 1 : 0));
      stop_at = 8 + 16 * (9 + (par_en ? 1 : 0));
      if (tick) begin
        if (m_mode == 0) begin
          if (!rxd) begin m_mode = 1; m_t = 0; m_hi = 0; m_acc = 0; end
          else begin
            m_hi++;
            if (m_armed && idle_thresh != 0 && m_hi % ct == 0 && m_hi / ct == idle_thresh) begin
              e_close = 1; m_armed = 0;
            end
          end
        end else if (m_mode == 1) begin
          m_t++;
          k = (m_t - 8) / 16;
          if (m_t == 8) begin
            if (rxd) m_mode = 0;
          end else if ((m_t - 8) % 16 == 0 && k >= 1 && k <= 8) begin
            if (rxd) m_acc += (1 << (k - 1));
          end else if (par_en && m_t == 8 + 16 * 9) begin
            m_pb = rxd;
          end else if (m_t == stop_at) begin
            e_valid = 1; e_data = m_acc; e_fr = !rxd;
            e_pe = par_en && rxd && (($countones(m_acc[7:0]) + m_pb) % 2 != (par_odd ? 1 : 0));
            e_brk = !rxd && m_acc == 0;
            m_armed = 1; m_hi = 0;
            if (e_brk) begin
              m_mode = 2; m_low = 0; e_bp = brk_irq_en;
              if (e_cnt < CMAX) e_cnt++;
            end else m_mode = 0;
          end
        end else begin
          if (rxd) begin
            e_len = 1 + m_low / ct;
            if (e_len > LMAX) e_len = LMAX;
            m_mode = 0;
          end else m_low++;
        end
      end
      if (brk_cnt_clr) e_cnt = 0;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check("R2 char_valid", char_valid, e_valid);
    if (e_valid) begin
      n_valid++;
      check("R2 char_data", char_data, e_data);
      check("R3 frame_err", frame_err, e_fr);
      check("R4 par_err", par_err, e_pe);
      check("R5 char_brk", char_brk, e_brk);
    end
    check("R5 brk_pulse", brk_pulse, e_bp);
    check("R6 brk_count", brk_count, e_cnt);
    check("R7 brk_len", brk_len, e_len);
    check("R8 idle_close", idle_close, e_close);
    if (idle_close) n_close++;
  end

  task automatic ticks(int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit stop_hi, input bit flip);
    rxd = 1'b0; ticks(16);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; ticks(16); end
    if (par_en) begin rxd = (^d) ^ par_odd ^ flip; ticks(16); end
    rxd = stop_hi; ticks(16);
    rxd = 1'b1; ticks(20);
  endtask

  task automatic brk(int low_ticks);
    rxd = 1'b0; ticks(low_ticks);
    rxd = 1'b1; ticks(20);
  endtask

  initial begin
    int nv;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 reset valid", char_valid, 0);
    check("R9 reset data", char_data, 0);
    check("R9 reset flags", {frame_err, par_err, char_brk, brk_pulse, idle_close}, 0);
    check("R9 reset count", brk_count, 0);
    check("R9 reset len", brk_len, 0);
    rst_n = 1'b1;
    ticks(20);

    // R2 plain characters
    send(8'h55, 1, 0); send(8'hA3, 1, 0); send(8'hFF, 1, 0); send(8'h01, 1, 0);
    check("R2 delivered", n_valid, 4);

    // R1 short glitch rejected
    nv = n_valid;
    rxd = 1'b0; ticks(4); rxd = 1'b1; ticks(40);
    check("R1 glitch no char", n_valid, nv);

    // R4 parity both senses, good and bad
    par_en = 1'b1;
    par_odd = 1'b0; send(8'h37, 1, 0); send(8'h37, 1, 1);
    par_odd = 1'b1; send(8'hC4, 1, 0); send(8'hC4, 1, 1);

    // R3 framing error, also with bad parity
    send(8'h5A, 0, 1);
    par_en = 1'b0;
    send(8'h81, 0, 0);

    // R5/R7 breaks: short with pulse masked, then long to saturate length
    brk_irq_en = 1'b0; brk(160);
    check("R7 short break len", brk_len, 1);
    brk_irq_en = 1'b1; brk(153 + 160 * 2 + 5);
    check("R7 three char break", brk_len, 3);
    par_en = 1'b1; brk(176 * 9);
    check("R7 saturated len", brk_len, LMAX);
    par_en = 1'b0;

    // R6 counter saturation then clear
    for (int i = 0; i < 6; i++) brk(170);
    check("R6 count saturated", brk_count, CMAX);
    @(negedge clk); brk_cnt_clr = 1'b1; @(negedge clk); brk_cnt_clr = 1'b0;
    check("R6 count cleared", brk_count, 0);
    brk(170);
    check("R6 count after clear", brk_count, 1);

    // R8 idle close once at threshold, disabled at zero
    idle_thresh = 3;
    send(8'h42, 1, 0); ticks(160 * 5);
    check("R8 one close", n_close, 1);
    idle_thresh = 0;
    send(8'h24, 1, 0); ticks(160 * 4);
    check("R8 disabled", n_close, 1);
    idle_thresh = 2;
    send(8'h99, 1, 0); ticks(150); send(8'h66, 1, 0); ticks(160 * 3);
    check("R8 reset by char", n_close, 2);

    ticks(10);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule